// File: doc/BRIEF.md
# Interrupt Redirection and Delivery Engine

This block sits between a bank of external interrupt request lines and the message fabric that carries interrupts to processors. Each pin has a 64-bit redirection entry, held by a separate register block and presented here as a flat input vector. The entry sets the pin's vector, delivery mode, destination, destination mode, input polarity, trigger mode and mask. The engine turns pin activity into request bits. It then hands out one delivery message at a time, in ascending pin order, over a valid/ready handshake.

Level-triggered pins carry an in-flight flag, the remote-pending bit, which the engine owns and reports back to the register block. A delivered level pin is not offered again until an end-of-interrupt arrives with a matching vector. At that point the pin is serviced again if its line is still active. Edge-triggered pins latch a request only while unmasked, and the request is cleared when the pin is delivered. Scanning is armed by events: a new request, a retired remote-pending flag, or the register block's entry-updated strobe.

Top module: `irq_route_engine`

## Requirements
- R1: When entry bit 13 (polarity) is 1, the pin's input level is inverted before the trigger logic sees it. An active-low level pin therefore requests while its line is low.
- R2: A level-triggered pin (entry bit 15 = 1) has its request bit follow the polarity-corrected level, and its delivered message carries trigger = 1. A level pin whose line has dropped is not redelivered after an end-of-interrupt.
- R3: An edge-triggered pin (bit 15 = 0) that is unmasked (bit 16 = 0) yields exactly one message per rising edge. The request bit is cleared when the pin is delivered, so a line held high gives no second message.
- R4: A rising edge on a masked edge-triggered pin is dropped. Unmasking the pin later and pulsing the update strobe produces no message.
- R5: Delivering a level-triggered pin sets its remote-pending flag, reported on `remote_pend[pin]`. While the flag is set, the pin is not delivered again.
- R6: An end-of-interrupt with vector V clears remote-pending on every pin whose flag is set and whose entry vector (bits 7:0) equals V. Such a pin is redelivered if it is unmasked and its request is still set. A non-matching vector changes nothing.
- R7: Message fields are taken from the entry: vector from bits 7:0, delivery mode from bits 10:8, destination mode from bit 11, destination from bits 63:56. Delivery mode codes are fixed 0, lowest priority 1, performance monitor 2, NMI 4, INIT 5, start-up 6 and external 7. In external mode the vector comes from `ext_vector` instead of the entry.
- R8: Input line 0 drives pin 2. Input line 2 has no effect, and pin 0 has no input source.
- R9: When several pins are eligible at once, the lowest-numbered pin is delivered first.
- R10: While `msg_valid` is high and `msg_ready` is low, the message and its pin index stay unchanged. At most one pin is granted per cycle.
- R11: An entry change takes effect only once the block is re-armed. A pending request that is unmasked while the engine is idle is delivered only after `rte_upd` pulses.
- R12: After reset, `msg_valid` is 0 and every remote-pending flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | NUM_PINS | Raw interrupt input lines |
| rte_flat | input | NUM_PINS*64 | Redirection entries, pin p at bits p*64 +: 64 |
| rte_upd | input | 1 | Entry-updated strobe from the register block |
| ext_vector | input | 8 | Vector used for pins in external delivery mode |
| eoi_valid | input | 1 | End-of-interrupt broadcast strobe |
| eoi_vector | input | 8 | Vector carried by the end-of-interrupt |
| msg_valid | output | 1 | Delivery message valid |
| msg_ready | input | 1 | Downstream accepts the message |
| msg_pin | output | $clog2(NUM_PINS) | Pin that produced the message |
| msg_dest | output | 8 | Destination field |
| msg_dest_mode | output | 1 | Destination mode |
| msg_deliv_mode | output | 3 | Delivery mode code |
| msg_vector | output | 8 | Interrupt vector |
| msg_trig | output | 1 | Trigger mode, 1 = level |
| remote_pend | output | NUM_PINS | Remote-pending flag per pin |

## Verification
The bench targets the remote-pending loop. It checks that a level pin gets no redelivery while its flag is set, and that it is delivered again after a matching end-of-interrupt but not after a wrong vector. A design that cleared the flag on any end-of-interrupt, or never re-serviced the pin, would emit or lose a message here. The bench raises an edge on a masked pin and then unmasks it, which catches designs that latch masked edges. It holds an edge line high to expose a request that is never cleared. It exercises the pin-0-to-2 remap, the choice of the external vector, and a stalled handshake with two pins pending, which reveals wrong priority or a payload that changes under stall.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  localparam int ENT_W     = 64;
  localparam int VEC_LSB   = 0;
  localparam int DM_LSB    = 8;
  localparam int DMODE_BIT = 11;
  localparam int POL_BIT   = 13;
  localparam int TRIG_BIT  = 15;
  localparam int MASK_BIT  = 16;
  localparam int DEST_LSB  = 56;

  typedef enum logic [2:0] {
    DM_FIXED   = 3'd0,
    DM_LOWPRI  = 3'd1,
    DM_PERFMON = 3'd2,
    DM_NMI     = 3'd4,
    DM_INIT    = 3'd5,
    DM_STARTUP = 3'd6,
    DM_EXTERN  = 3'd7
  } dmode_e;

  typedef struct packed {
    logic [7:0] dest;
    logic       dest_mode;
    dmode_e     dm;
    logic [7:0] vector;
    logic       trig;
    logic       mask;
    logic       pol;
  } rte_t;

  function automatic rte_t rte_unpack(input logic [ENT_W-1:0] e);
    rte_t r;
    r.dest      = e[DEST_LSB +: 8];
    r.dest_mode = e[DMODE_BIT];
    r.dm        = dmode_e'(e[DM_LSB +: 3]);
    r.vector    = e[VEC_LSB +: 8];
    r.trig      = e[TRIG_BIT];
    r.mask      = e[MASK_BIT];
    r.pol       = e[POL_BIT];
    return r;
  endfunction

  // polarity correction applied ahead of all trigger logic
  function automatic logic pin_level(input logic raw, input logic pol);
    return raw ^ pol;
  endfunction

  function automatic logic [7:0] pick_vector(input rte_t r, input logic [7:0] ext);
    return (r.dm == DM_EXTERN) ? ext : r.vector;
  endfunction

endpackage

// File: rtl/irq_pin_cell.sv
module irq_pin_cell import irq_route_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       raw,
  input  logic       mask,
  input  logic       trig,
  input  logic       pol,
  input  logic [7:0] vec,
  input  logic       eoi_valid,
  input  logic [7:0] eoi_vector,
  input  logic       grant,
  output logic       eligible,
  output logic       req_evt,
  output logic       retire,
  output logic       rp_q
);

  logic lvl, lvl_prev_q, rise, req_q, req_d;

  assign lvl  = pin_level(raw, pol);
  assign rise = lvl & ~lvl_prev_q;

  always_comb begin
    if (trig) req_d = lvl;
    else      req_d = (req_q & ~grant) | (rise & ~mask);
  end

  assign req_evt  = req_d & ~req_q;
  assign retire   = eoi_valid & rp_q & (vec == eoi_vector);
  assign eligible = req_q & ~mask & ~(trig & rp_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_prev_q <= 1'b0;
      req_q      <= 1'b0;
      rp_q       <= 1'b0;
    end else begin
      lvl_prev_q <= lvl;
      req_q      <= req_d;
      if (grant && trig) rp_q <= 1'b1;
      else if (retire)   rp_q <= 1'b0;
    end
  end

  // R4
  masked_edge_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig && mask && !req_q) |=> !req_q);

  // R5
  level_rp_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && trig) |=> rp_q);

  // R5
  no_redeliver_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && rp_q) |-> !grant);

  // R6
  eoi_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && !grant) |=> !rp_q);

endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int N  = 24,
  parameter int IW = 5
) (
  input  logic [N-1:0]  elig,
  output logic          any,
  output logic [IW-1:0] idx,
  output logic [N-1:0]  first_oh
);

  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (elig[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
  end

  // isolate lowest set bit
  assign first_oh = elig & ~(elig - N'(1));

endmodule

// File: rtl/irq_route_engine.sv
module irq_route_engine import irq_route_pkg::*; #(
  parameter int NUM_PINS = 24,
  localparam int PIN_W   = $clog2(NUM_PINS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_PINS-1:0]       irq_in,
  input  logic [NUM_PINS*ENT_W-1:0] rte_flat,
  input  logic                      rte_upd,
  input  logic [7:0]                ext_vector,
  input  logic                      eoi_valid,
  input  logic [7:0]                eoi_vector,
  output logic                      msg_valid,
  input  logic                      msg_ready,
  output logic [PIN_W-1:0]          msg_pin,
  output logic [7:0]                msg_dest,
  output logic                      msg_dest_mode,
  output logic [2:0]                msg_deliv_mode,
  output logic [7:0]                msg_vector,
  output logic                      msg_trig,
  output logic [NUM_PINS-1:0]       remote_pend
);

  rte_t                ent [NUM_PINS];
  logic [NUM_PINS-1:0] raw, elig, req_evt, retire, first_oh, grant;
  logic [PIN_W-1:0]    sel;
  logic                any_elig, scan_q, out_free, load;
  rte_t                sel_ent;

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    assign ent[g] = rte_unpack(rte_flat[g*ENT_W +: ENT_W]);
    if (g == 2) begin : g_remap
      assign raw[g] = irq_in[0];
    end else if (g == 0) begin : g_nosrc
      assign raw[g] = 1'b0;
    end else begin : g_direct
      assign raw[g] = irq_in[g];
    end
    irq_pin_cell u_cell (
      .clk        (clk),
      .rst_n      (rst_n),
      .raw        (raw[g]),
      .mask       (ent[g].mask),
      .trig       (ent[g].trig),
      .pol        (ent[g].pol),
      .vec        (ent[g].vector),
      .eoi_valid  (eoi_valid),
      .eoi_vector (eoi_vector),
      .grant      (grant[g]),
      .eligible   (elig[g]),
      .req_evt    (req_evt[g]),
      .retire     (retire[g]),
      .rp_q       (remote_pend[g])
    );
  end

  irq_pick #(.N(NUM_PINS), .IW(PIN_W)) u_pick (
    .elig     (elig),
    .any      (any_elig),
    .idx      (sel),
    .first_oh (first_oh)
  );

  assign out_free = !msg_valid || msg_ready;
  assign load     = scan_q && out_free && any_elig;
  assign grant    = first_oh & {NUM_PINS{load}};
  assign sel_ent  = ent[sel];

  // scan armed by request, retire or update events; idles when nothing eligible
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  scan_q <= 1'b0;
    else if ((|req_evt) || (|retire) || rte_upd) scan_q <= 1'b1;
    else if (scan_q && out_free && !any_elig)    scan_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msg_valid      <= 1'b0;
      msg_pin        <= '0;
      msg_dest       <= '0;
      msg_dest_mode  <= 1'b0;
      msg_deliv_mode <= '0;
      msg_vector     <= '0;
      msg_trig       <= 1'b0;
    end else if (load) begin
      msg_valid      <= 1'b1;
      msg_pin        <= sel;
      msg_dest       <= sel_ent.dest;
      msg_dest_mode  <= sel_ent.dest_mode;
      msg_deliv_mode <= sel_ent.dm;
      msg_vector     <= pick_vector(sel_ent, ext_vector);
      msg_trig       <= sel_ent.trig;
    end else if (msg_ready) begin
      msg_valid      <= 1'b0;
    end
  end

  // R10
  msg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable({msg_pin, msg_dest,
      msg_dest_mode, msg_deliv_mode, msg_vector, msg_trig})));

  // R10
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R10
  grant_when_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant) |-> out_free);

endmodule

// File: tb/irq_route_engine_tb.sv
module irq_route_engine_tb_top;
  localparam int N = 24;
  localparam int PW = $clog2(N);
  localparam logic [63:0] ENT_OFF = 64'h0000_0000_0001_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] irq_in = '0;
  logic [63:0] ent [N];
  logic [N*64-1:0] rte_flat;
  logic rte_upd = 1'b0, eoi_valid = 1'b0, msg_ready = 1'b1;
  logic [7:0] ext_vector = 8'h00, eoi_vector = 8'h00;
  logic msg_valid, msg_dest_mode, msg_trig;
  logic [PW-1:0] msg_pin;
  logic [7:0] msg_dest, msg_vector;
  logic [2:0] msg_deliv_mode;
  logic [N-1:0] remote_pend;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  always_comb for (int i = 0; i < N; i++) rte_flat[i*64 +: 64] = ent[i];

  irq_route_engine #(.NUM_PINS(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .rte_flat(rte_flat),
    .rte_upd(rte_upd), .ext_vector(ext_vector), .eoi_valid(eoi_valid),
    .eoi_vector(eoi_vector), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_pin(msg_pin), .msg_dest(msg_dest), .msg_dest_mode(msg_dest_mode),
    .msg_deliv_mode(msg_deliv_mode), .msg_vector(msg_vector),
    .msg_trig(msg_trig), .remote_pend(remote_pend));

  function automatic logic [63:0] mk_ent(input logic [7:0] vec, input logic [2:0] dm,
      input logic dmode, input logic pol, input logic trig, input logic mask,
      input logic [7:0] dest);
    return {dest, 39'b0, mask, trig, 1'b0, pol, 1'b0, dmode, dm, vec};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_msg(input int lim, output bit seen);
    seen = 0;
    for (int c = 0; c < lim && !seen; c++) begin
      @(negedge clk);
      if (msg_valid) seen = 1;
    end
  endtask

  task automatic expect_none(input int lim, input string req);
    bit seen = 0;
    for (int c = 0; c < lim; c++) begin
      @(negedge clk);
      if (msg_valid) seen = 1;
    end
    chk(req, seen, 0);
  endtask

  task automatic strobe();
    @(negedge clk); rte_upd = 1'b1;
    @(negedge clk); rte_upd = 1'b0;
  endtask

  task automatic send_eoi(input logic [7:0] v);
    @(negedge clk); eoi_valid = 1'b1; eoi_vector = v;
    @(negedge clk); eoi_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R12 valid", msg_valid, 0);
    chk("R12 remote_pend", remote_pend, 0);
  endtask

  task automatic t_edge();
    bit seen;
    ent[5] = mk_ent(8'h41, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h3C);
    strobe();
    irq_in[5] = 1'b1;
    wait_msg(8, seen);
    chk("R3 edge delivered", seen, 1);
    chk("R7 pin", msg_pin, 5);
    chk("R7 vector", msg_vector, 8'h41);
    chk("R7 dest", msg_dest, 8'h3C);
    chk("R7 dest mode", msg_dest_mode, 1);
    chk("R7 fixed mode", msg_deliv_mode, 0);
    chk("R3 trig edge", msg_trig, 0);
    expect_none(8, "R3 single message per edge");
    irq_in[5] = 1'b0;
    ent[5] = ENT_OFF;
  endtask

  task automatic t_masked_edge();
    ent[6] = mk_ent(8'h44, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h01);
    strobe();
    irq_in[6] = 1'b1;
    expect_none(5, "R4 masked edge no message");
    ent[6] = mk_ent(8'h44, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h01);
    strobe();
    expect_none(8, "R4 masked edge dropped");
    irq_in[6] = 1'b0;
    ent[6] = ENT_OFF;
  endtask

  task automatic t_level();
    bit seen;
    ent[9] = mk_ent(8'h52, 3'd1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h07);
    strobe();
    irq_in[9] = 1'b1;
    wait_msg(8, seen);
    chk("R2 level delivered", seen, 1);
    chk("R2 trig level", msg_trig, 1);
    chk("R7 lowest-priority mode", msg_deliv_mode, 1);
    chk("R5 remote pending set", remote_pend[9], 1);
    expect_none(8, "R5 no redelivery while pending");
    send_eoi(8'h53);
    expect_none(6, "R6 wrong vector no redelivery");
    chk("R6 wrong vector keeps flag", remote_pend[9], 1);
    send_eoi(8'h52);
    wait_msg(8, seen);
    chk("R6 matching eoi redelivers", seen, 1);
    chk("R6 redelivered vector", msg_vector, 8'h52);
    chk("R6 flag set again", remote_pend[9], 1);
    @(negedge clk); irq_in[9] = 1'b0;
    repeat (2) @(negedge clk);
    send_eoi(8'h52);
    expect_none(6, "R2 dropped level not redelivered");
    chk("R6 flag cleared", remote_pend[9], 0);
    ent[9] = ENT_OFF;
  endtask

  task automatic t_polarity();
    bit seen;
    irq_in[11] = 1'b1;
    @(negedge clk);
    ent[11] = mk_ent(8'h5B, 3'd0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h02);
    strobe();
    expect_none(6, "R1 inactive high line");
    irq_in[11] = 1'b0;
    wait_msg(8, seen);
    chk("R1 active-low delivered", seen, 1);
    chk("R1 vector", msg_vector, 8'h5B);
    @(negedge clk); irq_in[11] = 1'b1;
    repeat (2) @(negedge clk);
    send_eoi(8'h5B);
    ent[11] = ENT_OFF;
    @(negedge clk); irq_in[11] = 1'b0;
  endtask

  task automatic t_modes();
    bit seen;
    ext_vector = 8'hA7;
    ent[4] = mk_ent(8'h10, 3'd7, 1'b0, 1'b0, 1'b0, 1'b0, 8'h11);
    ent[7] = mk_ent(8'h22, 3'd4, 1'b0, 1'b0, 1'b0, 1'b0, 8'h81);
    strobe();
    irq_in[4] = 1'b1;
    wait_msg(8, seen);
    chk("R7 external delivered", seen, 1);
    chk("R7 external vector", msg_vector, 8'hA7);
    chk("R7 external mode", msg_deliv_mode, 7);
    irq_in[7] = 1'b1;
    wait_msg(8, seen);
    chk("R7 nmi delivered", seen, 1);
    chk("R7 nmi mode", msg_deliv_mode, 4);
    chk("R7 nmi vector", msg_vector, 8'h22);
    chk("R7 nmi dest", msg_dest, 8'h81);
    irq_in[4] = 1'b0; irq_in[7] = 1'b0;
    ent[4] = ENT_OFF; ent[7] = ENT_OFF;
  endtask

  task automatic t_remap();
    bit seen;
    ent[2] = mk_ent(8'h62, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h05);
    ent[0] = mk_ent(8'h60, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h05);
    strobe();
    irq_in[2] = 1'b1;
    expect_none(8, "R8 line 2 ignored");
    irq_in[0] = 1'b1;
    wait_msg(8, seen);
    chk("R8 line 0 delivered", seen, 1);
    chk("R8 line 0 on pin 2", msg_pin, 2);
    chk("R8 pin 2 vector", msg_vector, 8'h62);
    expect_none(4, "R8 pin 0 silent");
    irq_in[0] = 1'b0; irq_in[2] = 1'b0;
    ent[0] = ENT_OFF; ent[2] = ENT_OFF;
  endtask

  task automatic t_priority();
    bit seen;
    ent[12] = mk_ent(8'h70, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h09);
    ent[13] = mk_ent(8'h71, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h09);
    strobe();
    msg_ready = 1'b0;
    irq_in[13] = 1'b1; irq_in[12] = 1'b1;
    wait_msg(8, seen);
    chk("R9 first delivered", seen, 1);
    chk("R9 lowest pin first", msg_pin, 12);
    repeat (4) @(negedge clk);
    chk("R10 valid held", msg_valid, 1);
    chk("R10 pin held", msg_pin, 12);
    chk("R10 vector held", msg_vector, 8'h70);
    msg_ready = 1'b1;
    @(negedge clk);
    chk("R9 second valid", msg_valid, 1);
    chk("R9 second pin", msg_pin, 13);
    @(negedge clk);
    chk("R10 one message each", msg_valid, 0);
    irq_in[12] = 1'b0; irq_in[13] = 1'b0;
    ent[12] = ENT_OFF; ent[13] = ENT_OFF;
  endtask

  task automatic t_strobe();
    bit seen;
    ent[15] = mk_ent(8'h7F, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h0A);
    strobe();
    irq_in[15] = 1'b1;
    expect_none(6, "R11 masked level silent");
    ent[15] = mk_ent(8'h7F, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h0A);
    expect_none(8, "R11 no delivery before strobe");
    strobe();
    wait_msg(8, seen);
    chk("R11 delivered after strobe", seen, 1);
    chk("R11 pin", msg_pin, 15);
    @(negedge clk); irq_in[15] = 1'b0;
    repeat (2) @(negedge clk);
    send_eoi(8'h7F);
    ent[15] = ENT_OFF;
  endtask

  initial begin
    for (int i = 0; i < N; i++) ent[i] = ENT_OFF;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_edge();
    t_masked_edge();
    t_level();
    t_polarity();
    t_modes();
    t_remap();
    t_priority();
    t_strobe();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule